// File: doc/BRIEF.md
# Tagged Return Stream Packer

This block builds the device-to-host return stream of a 32-bit FIFO link. Upstream logic offers 32-bit data words, each with a 4-bit tag. The block gathers up to seven of them into an eight-word frame. The first word of a frame is a status word, and it carries the seven tags side by side. The seven data words follow it, in the order they were accepted.

Whenever no frame is on its way out, the block fills the link with a constant filler word. A host read therefore always returns data, and the host discards the filler. At least five filler words go out before every frame. A partly filled frame is not held forever: once its oldest word has waited for the flush interval, the frame is sent with its unused slots marked empty.

Both edges use a valid/ready handshake. The output side presents a word on `out_data` while `out_valid` is high, and the word moves when `out_ready` is high at a rising clock edge. The input side takes a word when `in_valid` and `in_ready` are both high at a rising edge.

Top module: `rsp_return_packer`

## Requirements
- R1: While `rst` is high, and at the first edge that releases it, `out_valid` and `in_ready` are 0. From the following cycle on, `out_valid` stays 1.
- R2: Outside a frame, `out_data` is the filler word 0x55556666.
- R3: The first word of a frame is the status word. The tag of slot k (k = 0..6, in arrival order) sits in bits [31-4k:28-4k], so slot 0 uses bits 31:28. Bits 3:0 hold the end nibble 0xE.
- R4: At least MIN_KEEPALIVE (5) filler words are transferred after reset, or after the end of the previous frame, before a status word is presented. A frame starts at the first filler transfer that brings the count to at least 5 while a frame is due.
- R5: A frame is due as soon as seven words are held. Its status word then carries all seven accepted tags.
- R6: A frame is also due once a non-empty buffer has aged FLUSH_CYCLES clock edges, counted from the edge after its first word was accepted. Unused slots go out as data 0x00000000 with tag 0xF.
- R7: Once presented, the eight words of a frame leave back to back, one per transfer, and `out_valid` stays high. While `out_ready` is low, `out_data` does not change.
- R8: `in_ready` is 0 during a frame and while seven words are held. Words offered then are not taken, and the next frame's contents show this.
- R9: Data word k of a frame is the k-th word accepted since the previous frame ended. The words arrive unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Upstream data word |
| in_tag | input | 4 | Status tag for that word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Link takes the output word |
| out_data | output | 32 | Filler, status or data word |

## Verification
The bench builds the block with FLUSH_CYCLES set to 16 and keeps MIN_KEEPALIVE at 5. The short flush interval makes partial frames common, even under random traffic. A single waiting word, three-word partials, and the timer racing the seventh arrival all occur many times within a few thousand cycles. Keeping five filler words means a frame start can be delayed by the filler rule, by stalls on `out_ready`, or by both. The sustained-offer phase drives seven-word frames back to back. Words are offered during the drain there, so the bench sees that they are refused.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int DW = 32;
    localparam int TW = 4;
    // one nibble per data slot plus the end nibble fills the status word
    localparam int FRAME_SLOTS = DW / TW - 1;

    typedef logic [DW-1:0] dword_t;
    typedef logic [TW-1:0] tag_t;

    typedef struct packed {
        dword_t data;
        tag_t   tag;
    } entry_t;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_FRAME = 1'b1
    } phase_e;

    localparam dword_t FILLER_WORD = 32'h5555_6666;
    localparam tag_t   TAG_EMPTY   = 4'hF;
    localparam tag_t   TAG_END     = 4'hE;

endpackage

// File: rtl/rsp_slot_buffer.sv
module rsp_slot_buffer
    import rsp_pkg::*;
#(
    parameter int SLOTS        = 7,
    parameter int FLUSH_CYCLES = 64,
    localparam int CW = $clog2(SLOTS + 1),
    localparam int AW = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  entry_t               wr_entry,
    input  logic                 clear,
    output entry_t [SLOTS-1:0]   slots,
    output logic   [CW-1:0]      count,
    output logic                 full,
    output logic                 frame_ready
);

    logic [CW-1:0] count_q;
    logic [AW-1:0] age_q;
    logic          flush_due;

    assign count       = count_q;
    assign full        = (count_q == CW'(SLOTS));
    assign flush_due   = (count_q != '0) && (age_q == AW'(FLUSH_CYCLES));
    assign frame_ready = full || flush_due;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (wr_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    // age of the oldest held word, saturating at the flush interval
    always_ff @(posedge clk) begin
        if (rst || clear || count_q == '0) begin
            age_q <= '0;
        end else if (age_q != AW'(FLUSH_CYCLES)) begin
            age_q <= age_q + 1'b1;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (wr_en && count_q == CW'(i)) begin
                slots[i] <= wr_entry;
            end
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    a_r8_no_write_on_clear: assert property (@(posedge clk) disable iff (rst)
        clear |-> !wr_en);

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count_q == '0) && (age_q == '0));

endmodule

// File: rtl/rsp_frame_pack.sv
module rsp_frame_pack
    import rsp_pkg::*;
#(
    parameter int SLOTS = 7,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  entry_t [SLOTS-1:0] slots,
    input  logic   [CW-1:0]    count,
    output dword_t [SLOTS:0]   beats
);

    dword_t status_w;

    always_comb begin
        status_w         = '0;
        status_w[TW-1:0] = TAG_END;
        for (int i = 0; i < SLOTS; i++) begin
            status_w[DW-1-TW*i -: TW] = (CW'(i) < count) ? slots[i].tag : TAG_EMPTY;
        end
    end

    assign beats[0] = status_w;

    for (genvar i = 0; i < SLOTS; i++) begin : g_beat
        assign beats[i+1] = (CW'(i) < count) ? slots[i].data : '0;
    end

endmodule

// File: rtl/rsp_frame_seq.sv
module rsp_frame_seq
    import rsp_pkg::*;
#(
    parameter int SLOTS         = 7,
    parameter int MIN_KEEPALIVE = 5,
    localparam int BW = $clog2(SLOTS + 1),
    localparam int KW = $clog2(MIN_KEEPALIVE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          frame_ready,
    output phase_e        phase,
    output logic [BW-1:0] beat,
    output logic          drain_done
);

    localparam logic [BW-1:0] LAST_BEAT = BW'(SLOTS);

    phase_e        phase_q;
    logic [BW-1:0] beat_q;
    logic [KW-1:0] ka_q;
    logic          enough;

    assign phase      = phase_q;
    assign beat       = beat_q;
    assign enough     = (ka_q >= KW'(MIN_KEEPALIVE - 1));
    assign drain_done = (phase_q == PH_FRAME) && fire && (beat_q == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FILL;
            beat_q  <= '0;
            ka_q    <= '0;
        end else if (fire) begin
            if (phase_q == PH_FILL) begin
                if (enough && frame_ready) begin
                    phase_q <= PH_FRAME;
                end
                beat_q <= '0;
                if (ka_q != KW'(MIN_KEEPALIVE)) begin
                    ka_q <= ka_q + 1'b1;
                end
            end else if (beat_q == LAST_BEAT) begin
                phase_q <= PH_FILL;
                beat_q  <= '0;
                ka_q    <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    a_r4_min_keepalive: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_q == PH_FRAME) |-> ($past(ka_q) >= KW'(MIN_KEEPALIVE - 1)));

    a_r7_beat_advance: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FRAME && fire && beat_q != LAST_BEAT)
        |=> (phase_q == PH_FRAME) && (beat_q == $past(beat_q) + 1'b1));

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(phase_q) && $stable(beat_q));

endmodule

// File: rtl/rsp_return_packer.sv
module rsp_return_packer
    import rsp_pkg::*;
#(
    parameter int FLUSH_CYCLES  = 64,
    parameter int MIN_KEEPALIVE = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic [3:0]  in_tag,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);

    localparam int SLOTS = FRAME_SLOTS;
    localparam int CW    = $clog2(SLOTS + 1);
    localparam int BW    = $clog2(SLOTS + 1);

    logic                 live_q;
    logic                 fire;
    logic                 wr_en;
    logic                 drain_done;
    logic                 full;
    logic                 frame_ready;
    logic [CW-1:0]        count;
    entry_t [SLOTS-1:0]   slots;
    entry_t               wr_entry;
    dword_t [SLOTS:0]     beats;
    phase_e               phase;
    logic [BW-1:0]        beat;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    assign out_valid     = live_q;
    assign fire          = live_q && out_ready;
    assign in_ready      = live_q && (phase == PH_FILL) && !full;
    assign wr_en         = in_valid && in_ready;
    assign wr_entry.data = in_data;
    assign wr_entry.tag  = in_tag;

    rsp_slot_buffer #(
        .SLOTS        (SLOTS),
        .FLUSH_CYCLES (FLUSH_CYCLES)
    ) u_buf (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_entry    (wr_entry),
        .clear       (drain_done),
        .slots       (slots),
        .count       (count),
        .full        (full),
        .frame_ready (frame_ready)
    );

    rsp_frame_pack #(
        .SLOTS (SLOTS)
    ) u_pack (
        .slots (slots),
        .count (count),
        .beats (beats)
    );

    rsp_frame_seq #(
        .SLOTS         (SLOTS),
        .MIN_KEEPALIVE (MIN_KEEPALIVE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .frame_ready (frame_ready),
        .phase       (phase),
        .beat        (beat),
        .drain_done  (drain_done)
    );

    assign out_data = (phase == PH_FRAME) ? beats[beat] : FILLER_WORD;

    a_r7_stall_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));

    a_r7_valid_held: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    a_r8_refuse_in_frame: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data != FILLER_WORD && phase == PH_FRAME
         && beat != BW'(SLOTS)) |=> !in_ready);

endmodule

// File: tb/rsp_return_packer_tb.sv
module rsp_return_packer_tb;

    localparam int SLOTS = 7;
    localparam int FLUSH = 16;
    localparam int MINKA = 5;
    localparam logic [31:0] KA = 32'h5555_6666;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [3:0]  in_tag = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    always #10 clk = ~clk;

    rsp_return_packer #(
        .FLUSH_CYCLES  (FLUSH),
        .MIN_KEEPALIVE (MINKA)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_tag    (in_tag),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // behavioural reference state
    bit          m_live;
    int          m_mode;   // 0 filler, 1 frame
    int          m_beat;
    int          m_ka;
    int          m_age;
    logic [31:0] q_d[$];
    logic [3:0]  q_t[$];
    bit          last_acc;
    bit          start_pending;
    int          src_seq;
    int          dut_run;
    bit          prev_v;
    logic [31:0] prev_d;
    int          checks;
    int          errors;
    int          cyc_count;
    int          lf = 7;

    function automatic bit exp_in_ready();
        return m_live && m_mode == 0 && q_d.size() < SLOTS;
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] w;
        w = '0;
        w[3:0] = 4'hE;
        for (int k = 0; k < SLOTS; k++)
            w[31-4*k -: 4] = (k < q_t.size()) ? q_t[k] : 4'hF;
        return w;
    endfunction

    function automatic logic [31:0] exp_data();
        if (m_mode == 0) return KA;
        if (m_beat == 0) return exp_status();
        if (m_beat - 1 < q_d.size()) return q_d[m_beat-1];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc_count);
        end
    endtask

    always @(posedge clk) begin
        cyc_count++;
        if (rst) begin
            m_live = 0; m_mode = 0; m_beat = 0; m_ka = 0; m_age = 0;
            q_d.delete(); q_t.delete(); last_acc = 0; start_pending = 0;
        end else begin
            bit fire, acc, frdy, cleared;
            int n0;
            fire = m_live && out_ready;
            acc  = exp_in_ready() && in_valid;
            n0   = q_d.size();
            frdy = (n0 == SLOTS) || (n0 > 0 && m_age >= FLUSH);
            cleared = 0;
            last_acc = acc;
            if (m_mode == 0) begin
                if (acc) begin q_d.push_back(in_data); q_t.push_back(in_tag); end
                if (fire) begin
                    if (m_ka >= MINKA - 1 && frdy) begin
                        m_mode = 1; m_beat = 0; start_pending = 1;
                    end
                    if (m_ka < MINKA) m_ka++;
                end
            end else if (fire) begin
                if (m_beat == SLOTS) begin
                    m_mode = 0; m_beat = 0; m_ka = 0;
                    q_d.delete(); q_t.delete(); cleared = 1;
                end else begin
                    m_beat++;
                end
            end
            if (cleared || n0 == 0) m_age = 0;
            else if (m_age < FLUSH) m_age++;
            m_live = 1;
        end
    end

    task automatic cyc();
        string tag;
        @(negedge clk);
        // out_ready still holds the value seen at the edge just passed
        if (prev_v && out_ready) begin
            if (prev_d == KA) dut_run++;
            else dut_run = 0;
        end
        if (prev_v && !out_ready)
            chk(out_data === prev_d, "R7 stalled word changed", out_data, prev_d);
        chk(out_valid === m_live, m_live ? "R7 valid" : "R1 valid in reset",
            {31'b0, out_valid}, {31'b0, m_live});
        chk(in_ready === exp_in_ready(), m_live ? "R8 in_ready" : "R1 in_ready in reset",
            {31'b0, in_ready}, {31'b0, exp_in_ready()});
        if (m_live) begin
            if (m_mode == 0) tag = "R2 filler";
            else if (m_beat == 0) tag = (q_d.size() == SLOTS) ? "R5 full status" : "R3 status";
            else if (m_beat - 1 < q_d.size()) tag = "R9 data order";
            else tag = "R6 empty slot";
            chk(out_data === exp_data(), tag, out_data, exp_data());
        end
        if (m_mode == 1 && m_beat == 0 && start_pending) begin
            chk(dut_run >= MINKA, "R4 filler run before frame", dut_run, MINKA);
            start_pending = 0;
        end
        if (last_acc) begin src_seq++; last_acc = 0; end
        in_data = {16'hC0DE, src_seq[15:0]};
        in_tag  = src_seq[3:0] ^ 4'h9;
        prev_v  = out_valid;
        prev_d  = out_data;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc_count > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc_count);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (4) cyc();
        rst = 1'b0;
        // R2: idle filler
        out_ready = 1'b1;
        repeat (20) cyc();
        // R5, R8, R9: sustained offer, full frames, words refused during drain
        in_valid = 1'b1;
        repeat (60) cyc();
        in_valid = 1'b0;
        // R6: leftovers flushed by the timer
        repeat (40) cyc();
        // R6, R7: single word, long stall mid-frame
        in_valid = 1'b1;
        cyc();
        in_valid = 1'b0;
        repeat (22) cyc();
        out_ready = 1'b0;
        repeat (12) cyc();
        for (int i = 0; i < 60; i++) begin
            out_ready = i[0];
            cyc();
        end
        out_ready = 1'b1;
        // R6: three words then flush
        in_valid = 1'b1;
        repeat (3) cyc();
        in_valid = 1'b0;
        repeat (50) cyc();
        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            lf = lf * 1103515245 + 12345;
            in_valid  = (lf[20:18] < ((i / 500) % 8));
            out_ready = (lf[25:23] != 3'd0) || (i[9] == 1'b0);
            cyc();
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (100) cyc();
        finish_run();
    end

endmodule